// File: doc/BRIEF.md
# Multi-Port Receive Packet Push Interface

This block sits on the physical-layer side of a packet bus and moves words out of several per-port receive buffers toward a link-layer device. Each buffer offers its head word on a valid/ready stream, together with a byte-level fill count and a flag saying that a packet end is held. The block picks a port, reads words from it, and places each word on a registered output bus. The bus carries a data word, a parity bit, a count of unused trailing bytes, start and end markers, an error marker, an address-cycle marker and a valid marker.

The link layer paces the bus with an active-low read enable. A low enable at a clock edge allows one step: a buffer read, or an address or idle cycle, with every bus output updated at that edge. A high enable freezes the bus and performs no read. In multi-port mode one enable lane (lane 0) paces every port, and each burst opens with an address cycle that names the port. In single-port mode each port has its own lane, and no address cycles are sent.

Back-pressure rules on the buffer side: a port must hold `in_valid` and its word steady until it sees `in_ready`. `in_ready` is a pop strobe that depends combinationally on `in_valid`, `rd_en_n` and the configuration, and it is raised for at most one port per cycle.

Top module: `rxpush_top`

## Requirements
- R1: A port is eligible only while `in_valid` is high and either its end-held flag is set or its byte count is at least `cfg_thresh`. While no port is eligible, no address or data cycle appears on the bus.
- R2: In multi-port mode (`cfg_multi`=1), a burst starts with one address cycle: `bus_addr`=1, `bus_valid`=0, and `bus_data` holding the zero-extended port index. The port's data words follow.
- R3: Every word read from a buffer appears with `bus_valid`=1 and `bus_addr`=0. Data, start, end, error and modulo are copied from that word. A step in which nothing is read outputs an idle cycle with every field 0. After reset the bus is idle, with `bus_par`=1.
- R4: When the governing enable lane is sampled low, at most one buffer word is popped, and all bus outputs take their new values at that edge.
- R5: When the governing enable lane is sampled high, no word is popped and every bus output keeps its value through that edge.
- R6: `bus_par` covers `bus_data` only. It is recomputed at every update: odd parity when `cfg_par_even`=0 (the default), even parity when `cfg_par_even`=1.
- R7: In multi-port mode lane 0 of `rd_en_n` governs every step. In single-port mode the lane of the port being read governs, a port may only be selected while its own lane is low, and no address cycles are emitted.
- R8: When several ports are eligible at a selection point, the first eligible port after the last selected one, in ascending index order with wrap-around, is chosen. After reset the search starts at port 0.
- R9: A burst ends after a word with the end marker, or once the burst's byte total reaches `BURST_BYTES`. A new selection happens only then. Each word counts `DATA_W/8` bytes, less its modulo on an end word.
- R10: The modulo field on an end word gives the number of unused trailing bytes, 0 meaning all bytes are used. It is passed to `bus_mod` unchanged.
- R11: `in_ready` is one-hot or zero, and is raised only for a port whose `in_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_multi | input | 1 | 1 = multi-port mode with address cycles, 0 = single-port mode |
| cfg_par_even | input | 1 | 0 = odd parity, 1 = even parity |
| cfg_thresh | input | LVL_W | Byte count that makes a port eligible |
| rd_en_n | input | NPORTS | Active-low read enable lanes |
| in_valid | input | NPORTS | Buffer head word present, per port |
| in_ready | output | NPORTS | Pop strobe, per port |
| in_data | input | NPORTS*DATA_W | Head data words, port p at slice p |
| in_sop | input | NPORTS | Head word starts a packet |
| in_eop | input | NPORTS | Head word ends a packet |
| in_err | input | NPORTS | Head word's packet is errored |
| in_mod | input | NPORTS*MOD_W | Unused trailing bytes of the head word |
| port_level | input | NPORTS*LVL_W | Bytes buffered per port |
| port_eop_held | input | NPORTS | A packet end is buffered, per port |
| bus_data | output | DATA_W | Bus data word or port address |
| bus_par | output | 1 | Parity of bus_data |
| bus_mod | output | MOD_W | Unused trailing bytes |
| bus_sop | output | 1 | Start of packet |
| bus_eop | output | 1 | End of packet |
| bus_err | output | 1 | Errored packet |
| bus_addr | output | 1 | Address cycle marker |
| bus_valid | output | 1 | Data cycle marker |

## Verification
A buffer filled only up to below the threshold, with no packet end, shows that byte-count eligibility is applied rather than mere presence of data. Topping it up shows that the threshold opens a burst, and that a burst waits through idle cycles for the rest of its packet. Mixed packet lengths on all four ports, with random enable stalls, separate round-robin order from fixed priority and burst-limit switching from end-only switching. The stalls also test that the bus holds while the enable is high. Runs repeated with even parity and in single-port mode, with independent random lanes, show which lane governs a step and that address cycles are dropped in single-port mode.

// File: rtl/rxpush_pkg.sv
package rxpush_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_DATA = 1'b1
  } rxp_state_e;
endpackage

// File: rtl/rxpush_rr_arb.sv
module rxpush_rr_arb #(
  parameter int N = 4,
  localparam int IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]  req,
  input  logic [IW-1:0] last,
  output logic [IW-1:0] gnt_idx,
  output logic          gnt_any
);
  always_comb begin
    gnt_idx = '0;
    gnt_any = 1'b0;
    for (int k = 1; k <= N; k++) begin
      int cand;
      cand = (int'(last) + k) % N;
      if (!gnt_any && req[cand]) begin
        gnt_any = 1'b1;
        gnt_idx = IW'(cand);
      end
    end
  end
endmodule

// File: rtl/rxpush_parity.sv
module rxpush_parity #(
  parameter int W = 32
) (
  input  logic [W-1:0] word,
  input  logic         even_sel,
  output logic         par
);
  logic xr;
  assign xr  = ^word;
  assign par = even_sel ? xr : ~xr;
endmodule

// File: rtl/rxpush_top.sv
module rxpush_top
  import rxpush_pkg::*;
#(
  parameter int NPORTS      = 4,
  parameter int DATA_W      = 32,
  parameter int LVL_W       = 16,
  parameter int BURST_BYTES = 32,
  localparam int BYTES  = DATA_W / 8,
  localparam int MOD_W  = (BYTES > 1) ? $clog2(BYTES) : 1,
  localparam int PIDX_W = (NPORTS > 1) ? $clog2(NPORTS) : 1,
  localparam int BC_W   = $clog2(BURST_BYTES + BYTES + 1) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     cfg_multi,
  input  logic                     cfg_par_even,
  input  logic [LVL_W-1:0]         cfg_thresh,
  input  logic [NPORTS-1:0]        rd_en_n,
  input  logic [NPORTS-1:0]        in_valid,
  output logic [NPORTS-1:0]        in_ready,
  input  logic [NPORTS*DATA_W-1:0] in_data,
  input  logic [NPORTS-1:0]        in_sop,
  input  logic [NPORTS-1:0]        in_eop,
  input  logic [NPORTS-1:0]        in_err,
  input  logic [NPORTS*MOD_W-1:0]  in_mod,
  input  logic [NPORTS*LVL_W-1:0]  port_level,
  input  logic [NPORTS-1:0]        port_eop_held,
  output logic [DATA_W-1:0]        bus_data,
  output logic                     bus_par,
  output logic [MOD_W-1:0]         bus_mod,
  output logic                     bus_sop,
  output logic                     bus_eop,
  output logic                     bus_err,
  output logic                     bus_addr,
  output logic                     bus_valid
);
  rxp_state_e        state;
  logic [PIDX_W-1:0] cur, last;
  logic [BC_W-1:0]   bytes;

  // eligibility per port: packet end held or enough bytes buffered
  logic [NPORTS-1:0] elig;
  for (genvar p = 0; p < NPORTS; p++) begin : g_elig
    logic [LVL_W-1:0] lvl;
    assign lvl     = port_level[p*LVL_W +: LVL_W];
    assign elig[p] = in_valid[p] & (port_eop_held[p] | (lvl >= cfg_thresh));
  end

  logic [NPORTS-1:0] req;
  logic [PIDX_W-1:0] gnt_idx;
  logic              gnt_any;
  assign req = cfg_multi ? elig : (elig & ~rd_en_n);

  rxpush_rr_arb #(.N(NPORTS)) u_arb (
    .req     (req),
    .last    (last),
    .gnt_idx (gnt_idx),
    .gnt_any (gnt_any)
  );

  // step control
  logic              go, start, emit_addr, read_word, pop, burst_done;
  logic [PIDX_W-1:0] sel;
  always_comb begin
    if (cfg_multi)             go = ~rd_en_n[0];
    else if (state == ST_IDLE) go = |(~rd_en_n);
    else                       go = ~rd_en_n[cur];
    start     = (state == ST_IDLE) && gnt_any;
    emit_addr = start && cfg_multi;
    sel       = (state == ST_IDLE) ? gnt_idx : cur;
    read_word = (state == ST_DATA) || (start && !cfg_multi);
    pop       = go && read_word && in_valid[sel];
  end

  // head word of the selected port
  logic [DATA_W-1:0] w_data;
  logic [MOD_W-1:0]  w_mod;
  logic              w_sop, w_eop, w_err;
  assign w_data = in_data[sel*DATA_W +: DATA_W];
  assign w_mod  = in_mod[sel*MOD_W +: MOD_W];
  assign w_sop  = in_sop[sel];
  assign w_eop  = in_eop[sel];
  assign w_err  = in_err[sel];

  // burst byte accounting
  logic [BC_W-1:0] base_bytes, add_bytes, bytes_sum;
  always_comb begin
    base_bytes = (state == ST_IDLE) ? '0 : bytes;
    add_bytes  = w_eop ? BC_W'(BYTES - int'(w_mod)) : BC_W'(BYTES);
    bytes_sum  = base_bytes + add_bytes;
    burst_done = w_eop || (bytes_sum >= BC_W'(BURST_BYTES));
  end

  // next bus contents
  logic [DATA_W-1:0] n_data;
  logic [MOD_W-1:0]  n_mod;
  logic              n_sop, n_eop, n_err, n_addr, n_valid, n_par;
  always_comb begin
    n_data  = '0;
    n_mod   = '0;
    n_sop   = 1'b0;
    n_eop   = 1'b0;
    n_err   = 1'b0;
    n_addr  = 1'b0;
    n_valid = 1'b0;
    if (emit_addr) begin
      n_data = DATA_W'(gnt_idx);
      n_addr = 1'b1;
    end else if (pop) begin
      n_data  = w_data;
      n_mod   = w_mod;
      n_sop   = w_sop;
      n_eop   = w_eop;
      n_err   = w_err;
      n_valid = 1'b1;
    end
  end

  rxpush_parity #(.W(DATA_W)) u_par (
    .word     (n_data),
    .even_sel (cfg_par_even),
    .par      (n_par)
  );

  always_comb begin
    in_ready = '0;
    if (pop) in_ready[sel] = 1'b1;
  end

  // control state
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cur   <= '0;
      last  <= PIDX_W'(NPORTS - 1);
      bytes <= '0;
    end else if (go) begin
      if (emit_addr) begin
        state <= ST_DATA;
        cur   <= gnt_idx;
        last  <= gnt_idx;
        bytes <= '0;
      end else if (pop) begin
        if (state == ST_IDLE) begin
          cur  <= gnt_idx;
          last <= gnt_idx;
        end
        state <= burst_done ? ST_IDLE : ST_DATA;
        bytes <= burst_done ? '0 : bytes_sum;
      end
    end
  end

  // bus output register: loads only on a permitted step
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bus_data  <= '0;
      bus_par   <= 1'b1;
      bus_mod   <= '0;
      bus_sop   <= 1'b0;
      bus_eop   <= 1'b0;
      bus_err   <= 1'b0;
      bus_addr  <= 1'b0;
      bus_valid <= 1'b0;
    end else if (go) begin
      bus_data  <= n_data;
      bus_par   <= n_par;
      bus_mod   <= n_mod;
      bus_sop   <= n_sop;
      bus_eop   <= n_eop;
      bus_err   <= n_err;
      bus_addr  <= n_addr;
      bus_valid <= n_valid;
    end
  end
endmodule

// File: rtl/rxpush_chk.sv
module rxpush_chk #(
  parameter int NPORTS      = 4,
  parameter int DATA_W      = 32,
  parameter int LVL_W       = 16,
  parameter int BURST_BYTES = 32,
  localparam int BYTES = DATA_W / 8,
  localparam int MOD_W = (BYTES > 1) ? $clog2(BYTES) : 1
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     cfg_multi,
  input logic                     cfg_par_even,
  input logic [LVL_W-1:0]         cfg_thresh,
  input logic [NPORTS-1:0]        rd_en_n,
  input logic [NPORTS-1:0]        in_valid,
  input logic [NPORTS-1:0]        in_ready,
  input logic [NPORTS*DATA_W-1:0] in_data,
  input logic [NPORTS-1:0]        in_sop,
  input logic [NPORTS-1:0]        in_eop,
  input logic [NPORTS-1:0]        in_err,
  input logic [NPORTS*MOD_W-1:0]  in_mod,
  input logic [NPORTS*LVL_W-1:0]  port_level,
  input logic [NPORTS-1:0]        port_eop_held,
  input logic [DATA_W-1:0]        bus_data,
  input logic                     bus_par,
  input logic [MOD_W-1:0]         bus_mod,
  input logic                     bus_sop,
  input logic                     bus_eop,
  input logic                     bus_err,
  input logic                     bus_addr,
  input logic                     bus_valid
);
  assert_one_pop_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(in_ready));

  assert_pop_needs_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready & ~in_valid) == '0);

  assert_no_pop_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_multi && rd_en_n[0]) |-> (in_ready == '0));

  assert_hold_on_stall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_multi && rd_en_n[0]) |=> ($stable(bus_data) && $stable(bus_par) &&
      $stable(bus_valid) && $stable(bus_addr) && $stable(bus_sop) &&
      $stable(bus_eop) && $stable(bus_err) && $stable(bus_mod)));

  assert_pop_shows_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready != '0) |=> (bus_valid && !bus_addr));

  assert_addr_not_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_addr && bus_valid));

  assert_no_addr_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_multi && $stable(cfg_multi)) |=> !$rose(bus_addr));

  assert_parity_sense_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_valid || bus_addr) && $stable(cfg_par_even)) |->
      (bus_par == (cfg_par_even ? (^bus_data) : ~(^bus_data))));
endmodule

bind rxpush_top rxpush_chk #(
  .NPORTS(NPORTS), .DATA_W(DATA_W), .LVL_W(LVL_W), .BURST_BYTES(BURST_BYTES)
) u_chk (.*);

// File: tb/tb_rxpush_top.sv
module tb_rxpush_top;
  localparam int CLK_PERIOD = 10;
  localparam int NP    = 4;
  localparam int DW    = 32;
  localparam int LW    = 16;
  localparam int BURST = 32;
  localparam int BY    = DW / 8;
  localparam int MW    = 2;

  typedef struct {
    logic [DW-1:0] data;
    logic [MW-1:0] md;
    logic          sop, eop, err;
  } wd_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_multi = 1'b1, cfg_par_even = 1'b0;
  logic [LW-1:0] cfg_thresh = LW'(16);
  logic [NP-1:0] rd_en_n = '1, in_valid = '0, in_ready;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0] in_sop = '0, in_eop = '0, in_err = '0, port_eop_held = '0;
  logic [NP*MW-1:0] in_mod = '0;
  logic [NP*LW-1:0] port_level = '0;
  logic [DW-1:0] bus_data;
  logic bus_par, bus_sop, bus_eop, bus_err, bus_addr, bus_valid;
  logic [MW-1:0] bus_mod;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxpush_top #(.NPORTS(NP), .DATA_W(DW), .LVL_W(LW), .BURST_BYTES(BURST)) dut (.*);

  wd_t fq[NP][$];
  int checks = 0, fails = 0, cyc = 0;
  int stall_pct = 30;
  string tag = "R3";

  // reference state
  int m_state = 0, m_cur = 0, m_last = NP - 1, m_bytes = 0;
  logic [DW-1:0] e_data = '0;
  logic [MW-1:0] e_mod = '0;
  logic e_par = 1'b1, e_sop = 0, e_eop = 0, e_err = 0, e_addr = 0, e_valid = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic pbit(logic [DW-1:0] d);
    return cfg_par_even ? ^d : ~^d;
  endfunction

  task automatic push_pkt(int p, int n, logic err);
    for (int i = 0; i < n; i++) begin
      wd_t w;
      w.data = $urandom;
      w.sop  = (i == 0);
      w.eop  = (i == n - 1);
      w.err  = err && (i == n - 1);
      w.md   = w.eop ? MW'($urandom % BY) : '0;
      fq[p].push_back(w);
    end
  endtask

  task automatic drive_inputs();
    for (int p = 0; p < NP; p++) begin
      logic held;
      held = 1'b0;
      foreach (fq[p][i]) if (fq[p][i].eop) held = 1'b1;
      in_valid[p]            = fq[p].size() > 0;
      port_level[p*LW +: LW] = LW'(fq[p].size() * BY);
      port_eop_held[p]       = held;
      if (fq[p].size() > 0) begin
        in_data[p*DW +: DW] = fq[p][0].data;
        in_mod[p*MW +: MW]  = fq[p][0].md;
        in_sop[p]           = fq[p][0].sop;
        in_eop[p]           = fq[p][0].eop;
        in_err[p]           = fq[p][0].err;
      end else begin
        in_data[p*DW +: DW] = '0;
        in_mod[p*MW +: MW]  = '0;
        in_sop[p] = 0; in_eop[p] = 0; in_err[p] = 0;
      end
    end
  endtask

  // one clock step: compare, drive, predict, advance
  task automatic step();
    bit go, pick;
    int g, popp;
    logic [NP-1:0] exp_rdy;
    @(negedge clk);
    cyc++;
    chk(tag, "bus_valid", bus_valid, e_valid);
    chk(tag, "bus_addr", bus_addr, e_addr);
    chk(tag, "bus_data", bus_data, e_data);
    chk("R10", "bus_mod", bus_mod, e_mod);
    chk(tag, "bus_sop/eop/err", {bus_sop, bus_eop, bus_err}, {e_sop, e_eop, e_err});
    chk("R6", "bus_par", bus_par, e_par);
    for (int p = 0; p < NP; p++) rd_en_n[p] = (($urandom % 100) < stall_pct);
    drive_inputs();
    // selection (R1, R8)
    pick = 0; g = 0;
    if (m_state == 0)
      for (int k = 1; k <= NP; k++) begin
        int c;
        c = (m_last + k) % NP;
        if (!pick && fq[c].size() > 0 && (port_eop_held[c] || fq[c].size() * BY >= cfg_thresh)
            && (cfg_multi || !rd_en_n[c])) begin
          pick = 1; g = c;
        end
      end
    if (cfg_multi) go = !rd_en_n[0];
    else if (m_state == 0) go = (rd_en_n != '1);
    else go = !rd_en_n[m_cur];
    popp = -1;
    if (go) begin
      {e_data, e_mod, e_sop, e_eop, e_err, e_addr, e_valid} = '0;
      if (m_state == 0 && pick && cfg_multi) begin
        e_data = DW'(g); e_addr = 1;
        m_state = 1; m_cur = g; m_last = g; m_bytes = 0;
      end else begin
        int sp;
        sp = (m_state == 0) ? g : m_cur;
        if ((m_state == 1 || pick) && fq[sp].size() > 0) begin
          wd_t w;
          int b;
          w = fq[sp][0];
          popp = sp;
          e_data = w.data; e_mod = w.md; e_sop = w.sop; e_eop = w.eop; e_err = w.err;
          e_valid = 1;
          if (m_state == 0) begin m_cur = g; m_last = g; m_bytes = 0; end
          b = m_bytes + (w.eop ? BY - int'(w.md) : BY);
          if (w.eop || b >= BURST) begin m_state = 0; m_bytes = 0; end
          else begin m_state = 1; m_bytes = b; end
        end
      end
      e_par = pbit(e_data);
    end
    #1;
    exp_rdy = '0;
    if (popp >= 0) exp_rdy[popp] = 1'b1;
    chk((popp >= 0) ? "R4" : "R5", "in_ready", in_ready, exp_rdy);
    @(posedge clk);
    #1;
    if (popp >= 0) void'(fq[popp].pop_front());
  endtask

  function automatic bit all_empty();
    for (int p = 0; p < NP; p++) if (fq[p].size() > 0) return 0;
    return 1;
  endfunction

  task automatic drain();
    while (!all_empty() && cyc < 150000) step();
    for (int i = 0; i < 6; i++) step();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R3: reset state is idle with odd parity of zero
    chk("R3", "reset valid", bus_valid, 0);
    chk("R3", "reset addr", bus_addr, 0);
    chk("R6", "reset par", bus_par, 1);

    // R1: 12 bytes buffered, no end, threshold 16 -> nothing moves
    tag = "R1";
    stall_pct = 0;
    push_pkt(2, 5, 0);
    begin
      wd_t tail[$];
      tail = fq[2][3:4];
      fq[2] = fq[2][0:2];
      repeat (6) step();
      @(negedge clk);
      chk("R1", "below threshold no cycle", {bus_valid, bus_addr}, 2'b00);
      // R1: reaching the threshold opens the burst (R2 address first)
      fq[2].push_back(tail[0]);
      tag = "R2";
      repeat (8) step();
      fq[2].push_back(tail[1]);
      drain();
    end

    // R8 R9 R5 R7: all ports, mixed lengths, random stalls, multi-port
    tag = "R9";
    stall_pct = 30;
    for (int r = 0; r < 6; r++)
      for (int p = 0; p < NP; p++) push_pkt(p, 1 + ($urandom % 12), ($urandom % 4) == 0);
    drain();

    // R8: single-word packets on every port show rotation order
    tag = "R8";
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < NP; p++) push_pkt(p, 1, 0);
    drain();

    // R6: even parity
    tag = "R6";
    cfg_par_even = 1'b1;
    for (int p = 0; p < NP; p++) push_pkt(p, 2 + ($urandom % 6), 0);
    drain();
    cfg_par_even = 1'b0;

    // R7: single-port mode, per-port lanes, no address cycles
    tag = "R7";
    cfg_multi = 1'b0;
    stall_pct = 50;
    for (int r = 0; r < 4; r++)
      for (int p = 0; p < NP; p++) push_pkt(p, 1 + ($urandom % 10), 0);
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 180000);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule